// File: doc/BRIEF.md
# Circular Buffer Data Address Generator

This block turns pointer-based memory accesses into 24-bit addresses. It keeps four 16-bit index pointers. Each pointer has its own buffer length and buffer base. Four modify registers are shared by all pointers, and one 8-bit page register supplies the upper address bits. On every access the caller names a pointer, an addressing mode, and either a modify register or an 8-bit signed immediate. The block returns the address one cycle later and, where the mode requires it, writes the modified pointer back.

When a pointer's length is nonzero, every modified value is folded back into the window from base to base plus length minus one, which gives hardware circular buffers. The folding acts on the low 16 bits only, because a buffer lives inside one 64K-word page. A length of zero gives plain 16-bit wraparound.

Two complete register sets exist. A level select input chooses the active set in the same cycle, so an interrupt handler can switch context without saving the other set. All register writes go through one write port and land in the active set.

Top module: `cbuf_dag`

## Requirements
- R1: After reset, every pointer, modify, length, base and page register in both sets reads as zero, and `addr_valid` is 0.
- R2: Mode 0 (post-modify by register) outputs `{page, pointer}` and then stores the wrapped value of pointer plus the selected modify register.
- R3: Mode 1 (pre-modify, keep) outputs `{page, wrap(pointer + modify register)}` and leaves the stored pointer unchanged.
- R4: Mode 2 (pre-modify by immediate) outputs `{page, wrap(pointer + sext(imm))}` and stores that same value. The 8-bit immediate is sign-extended to 16 bits.
- R5: Mode 3 (post-modify by immediate) outputs `{page, pointer}` and then stores `wrap(pointer + sext(imm))`.
- R6: When the pointer's length is zero, wrap is plain 16-bit two's-complement addition. For example, 0xFFFE + 5 gives 0x0003.
- R7: When the length is nonzero and the sum is at or above base + length, the length is subtracted, so the result stays inside the window (with |modifier| < length).
- R8: When the length is nonzero and the sum falls below base, the length is added.
- R9: `addr_out[23:16]` always carries the active page register. A carry or borrow out of the low 16 bits never changes it.
- R10: `bank_sel` (0 = primary, 1 = secondary) picks the set used by accesses and by writes in the same cycle. The inactive set keeps its contents.
- R11: The write port selector `wr_sel` is `{kind[2:0], index[1:0]}`, with kind 0 = pointer, 1 = modify, 2 = length, 3 = base, 4 = page (page uses `wr_data[7:0]`). A pointer write in the same cycle as an update of that pointer wins.
- R12: `addr_valid` and `addr_out` are registered. `addr_valid` is 1 exactly in the cycle after a cycle with `acc_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Active register set: 0 primary, 1 secondary |
| acc_valid | input | 1 | Access request this cycle |
| acc_mode | input | 2 | Addressing mode 0..3 (see R2 to R5) |
| acc_ptr | input | 2 | Index pointer selected |
| acc_msel | input | 2 | Modify register selected (modes 0 and 1) |
| acc_imm | input | 8 | Signed immediate modifier (modes 2 and 3) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | `{kind, index}` register selector |
| wr_data | input | 16 | Write data |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | 24 | `{page, low address}` |

## Verification
The bench builds the block with its default widths: four 16-bit pointers, an 8-bit immediate and an 8-bit page. With those widths, both wrap directions and the 16-bit rollover at a zero length are reachable with short windows (lengths of 1 to 200). Short windows also let immediates and modify values land on every fold case within a few accesses. Directed steps cover set switching, page carry isolation and the write-versus-update collision. Seeded random windows, pointers and modifiers then exercise all four modes against a model of both register sets.

// File: rtl/cbuf_dag_pkg.sv
package cbuf_dag_pkg;

    localparam int LOW_W  = 16;
    localparam int IMM_W  = 8;
    localparam int PAGE_W = 8;
    localparam int NPTR   = 4;
    localparam int NMOD   = 4;
    localparam int IDX_W  = $clog2(NPTR);
    localparam int MIDX_W = $clog2(NMOD);
    localparam int ADDR_W = PAGE_W + LOW_W;
    localparam int KIND_W = 3;
    localparam int SEL_W  = KIND_W + IDX_W;

    typedef enum logic [1:0] {
        MODE_POST_MREG  = 2'd0,
        MODE_PRE_KEEP   = 2'd1,
        MODE_PRE_IMM    = 2'd2,
        MODE_POST_IMM   = 2'd3
    } acc_mode_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_PTR  = 3'd0,
        KIND_MOD  = 3'd1,
        KIND_LEN  = 3'd2,
        KIND_BASE = 3'd3,
        KIND_PAGE = 3'd4
    } reg_kind_e;

    typedef struct packed {
        logic [LOW_W-1:0] ptr;
        logic [LOW_W-1:0] modv;
        logic [LOW_W-1:0] len;
        logic [LOW_W-1:0] base;
    } wrap_in_t;

    function automatic logic [LOW_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(LOW_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic mode_is_pre(input acc_mode_e m);
        return (m == MODE_PRE_KEEP) || (m == MODE_PRE_IMM);
    endfunction

    function automatic logic mode_writes_back(input acc_mode_e m);
        return m != MODE_PRE_KEEP;
    endfunction

endpackage

// File: rtl/cbuf_dag_wrap.sv
module cbuf_dag_wrap
    import cbuf_dag_pkg::*;
(
    input  wrap_in_t         win,
    output logic [LOW_W-1:0] nxt
);
    localparam int EXT_W = LOW_W + 2;

    logic signed [EXT_W-1:0] sum_s;
    logic signed [EXT_W-1:0] lo_s;
    logic signed [EXT_W-1:0] hi_s;
    logic signed [EXT_W-1:0] len_s;

    always_comb begin
        sum_s = $signed({2'b00, win.ptr}) + $signed({{2{win.modv[LOW_W-1]}}, win.modv});
        lo_s  = $signed({2'b00, win.base});
        len_s = $signed({2'b00, win.len});
        hi_s  = lo_s + len_s;
        if (win.len == '0)
            nxt = LOW_W'(sum_s);
        else if (sum_s >= hi_s)
            nxt = LOW_W'(sum_s - len_s);
        else if (sum_s < lo_s)
            nxt = LOW_W'(sum_s + len_s);
        else
            nxt = LOW_W'(sum_s);
    end

    // Guard for the window check: pointer inside a window that fits the page,
    // modifier magnitude below the length.
    logic [LOW_W-1:0] mag;
    logic [LOW_W:0]   win_end;
    logic             in_win;
    assign mag     = win.modv[LOW_W-1] ? (~win.modv + 1'b1) : win.modv;
    assign win_end = {1'b0, win.base} + {1'b0, win.len};
    assign in_win  = (win.len != '0) && (win.ptr >= win.base) &&
                     ({1'b0, win.ptr} < win_end) && (win_end <= {1'b1, {LOW_W{1'b0}}}) &&
                     (mag < win.len);

    always_comb begin
        if (in_win) begin
            assert_stay_in_window_R7: assert (nxt >= win.base && {1'b0, nxt} < win_end)
                else $error("wrapped pointer left its window");
        end
    end

endmodule

// File: rtl/cbuf_dag_regs.sv
module cbuf_dag_regs
    import cbuf_dag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bank,
    input  logic                wr_en,
    input  reg_kind_e           wr_kind,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [LOW_W-1:0]    wr_data,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [LOW_W-1:0]    upd_val,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [MIDX_W-1:0]   rd_midx,
    output logic [LOW_W-1:0]    rd_ptr,
    output logic [LOW_W-1:0]    rd_mod,
    output logic [LOW_W-1:0]    rd_len,
    output logic [LOW_W-1:0]    rd_base,
    output logic [PAGE_W-1:0]   rd_page
);
    localparam int NBANK = 2;

    logic [NBANK-1:0][NPTR-1:0][LOW_W-1:0] ptr_q;
    logic [NBANK-1:0][NMOD-1:0][LOW_W-1:0] mod_q;
    logic [NBANK-1:0][NPTR-1:0][LOW_W-1:0] len_q;
    logic [NBANK-1:0][NPTR-1:0][LOW_W-1:0] base_q;
    logic [NBANK-1:0][PAGE_W-1:0]          page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
            page_q <= '0;
        end else begin
            if (upd_en)
                ptr_q[bank][upd_idx] <= upd_val;
            // later assignment: a pointer write overrides the update
            if (wr_en) begin
                case (wr_kind)
                    KIND_PTR:  ptr_q[bank][wr_idx]  <= wr_data;
                    KIND_MOD:  mod_q[bank][MIDX_W'(wr_idx)] <= wr_data;
                    KIND_LEN:  len_q[bank][wr_idx]  <= wr_data;
                    KIND_BASE: base_q[bank][wr_idx] <= wr_data;
                    KIND_PAGE: page_q[bank]         <= wr_data[PAGE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign rd_ptr  = ptr_q[bank][rd_idx];
    assign rd_mod  = mod_q[bank][rd_midx];
    assign rd_len  = len_q[bank][rd_idx];
    assign rd_base = base_q[bank][rd_idx];
    assign rd_page = page_q[bank];

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !(wr_en && wr_kind == KIND_PTR)) |=> $stable(ptr_q))
        else $error("pointer changed without update or write");

    assert_other_bank_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ptr_q[~$past(bank)] == $past(ptr_q[~bank]) &&
                  page_q[~$past(bank)] == $past(page_q[~bank])))
        else $error("inactive set was modified");

    assert_wr_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == KIND_PTR) |=> (ptr_q[$past(bank)][$past(wr_idx)] == $past(wr_data)))
        else $error("pointer write lost against update");

endmodule

// File: rtl/cbuf_dag.sv
module cbuf_dag
    import cbuf_dag_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bank_sel,
    input  logic               acc_valid,
    input  logic [1:0]         acc_mode,
    input  logic [IDX_W-1:0]   acc_ptr,
    input  logic [MIDX_W-1:0]  acc_msel,
    input  logic [IMM_W-1:0]   acc_imm,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [LOW_W-1:0]   wr_data,
    output logic               addr_valid,
    output logic [ADDR_W-1:0]  addr_out
);
    acc_mode_e         mode;
    reg_kind_e         wr_kind;
    logic [LOW_W-1:0]  rd_ptr, rd_mod, rd_len, rd_base;
    logic [PAGE_W-1:0] rd_page;
    logic [LOW_W-1:0]  nxt;
    logic [LOW_W-1:0]  low_sel;
    logic              upd_en;
    wrap_in_t          win;

    assign mode    = acc_mode_e'(acc_mode);
    assign wr_kind = reg_kind_e'(wr_sel[SEL_W-1:IDX_W]);

    cbuf_dag_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .bank    (bank_sel),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_sel[IDX_W-1:0]),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_idx (acc_ptr),
        .upd_val (nxt),
        .rd_idx  (acc_ptr),
        .rd_midx (acc_msel),
        .rd_ptr  (rd_ptr),
        .rd_mod  (rd_mod),
        .rd_len  (rd_len),
        .rd_base (rd_base),
        .rd_page (rd_page)
    );

    always_comb begin
        win.ptr  = rd_ptr;
        win.modv = acc_mode[1] ? sext_imm(acc_imm) : rd_mod;
        win.len  = rd_len;
        win.base = rd_base;
    end

    cbuf_dag_wrap u_wrap (
        .win (win),
        .nxt (nxt)
    );

    assign upd_en  = acc_valid && mode_writes_back(mode);
    assign low_sel = mode_is_pre(mode) ? nxt : rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= acc_valid;
            if (acc_valid)
                addr_out <= {rd_page, low_sel};
        end
    end

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> addr_valid)
        else $error("access gave no valid address");

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !addr_valid)
        else $error("valid without access");

    assert_page_bits_R9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (addr_out[ADDR_W-1:LOW_W] == $past(rd_page)))
        else $error("page bits disturbed");

    assert_post_old_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !mode_is_pre(mode)) |=> (addr_out[LOW_W-1:0] == $past(rd_ptr)))
        else $error("post-modify did not output old pointer");

endmodule

// File: tb/cbuf_dag_bench.sv
`timescale 1ns/1ps
module cbuf_dag_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_mode = '0;
    logic [1:0]  acc_ptr = '0;
    logic [1:0]  acc_msel = '0;
    logic [7:0]  acc_imm = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        addr_valid;
    logic [23:0] addr_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model of both register sets
    int m_ptr [2][4];
    int m_mod [2][4];
    int m_len [2][4];
    int m_base[2][4];
    int m_page[2];

    always #2 clk = ~clk;

    cbuf_dag u_cbuf_dag (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .acc_valid(acc_valid),
        .acc_mode(acc_mode), .acc_ptr(acc_ptr), .acc_msel(acc_msel), .acc_imm(acc_imm),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    function automatic int wrap_model(int p, int m, int len, int base);
        int s = p + m;
        if (len != 0) begin
            if (s >= base + len) s = s - len;
            else if (s < base) s = s + len;
        end
        return s & 32'hFFFF;
    endfunction

    function automatic int sext16(int v);
        return (v & 16'h8000) ? ((v & 16'hFFFF) - 65536) : (v & 16'hFFFF);
    endfunction

    function automatic int sext8(int v);
        return (v & 8'h80) ? ((v & 8'hFF) - 256) : (v & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one cycle: optional access and optional write, then check the result
    task automatic step(input bit b, input bit da, input int mode, input int p, input int ms,
                        input int imm, input bit dw, input int kind, input int idx,
                        input int data, input string tag);
        bit exp_v;
        int exp_a = 0;
        int nv;
        int mv;
        bank_sel  = b;
        acc_valid = da;
        acc_mode  = 2'(mode);
        acc_ptr   = 2'(p);
        acc_msel  = 2'(ms);
        acc_imm   = 8'(imm);
        wr_en     = dw;
        wr_sel    = {3'(kind), 2'(idx)};
        wr_data   = 16'(data);
        exp_v = da;
        if (da) begin
            mv = (mode >= 2) ? sext8(imm) : sext16(m_mod[b][ms]);
            nv = wrap_model(m_ptr[b][p], mv, m_len[b][p], m_base[b][p]);
            exp_a = (m_page[b] << 16) | ((mode == 1 || mode == 2) ? nv : m_ptr[b][p]);
            if (mode != 1) m_ptr[b][p] = nv;
        end
        if (dw) begin
            case (kind)
                0: m_ptr[b][idx]  = data & 16'hFFFF;
                1: m_mod[b][idx]  = data & 16'hFFFF;
                2: m_len[b][idx]  = data & 16'hFFFF;
                3: m_base[b][idx] = data & 16'hFFFF;
                4: m_page[b]      = data & 8'hFF;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(addr_valid == exp_v, {tag, " valid"}, int'(addr_valid), int'(exp_v));
        if (exp_v)
            check(addr_out == 24'(exp_a), {tag, " addr"}, int'(addr_out), exp_a);
        acc_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic wr(input bit b, input int kind, input int idx, input int data, input string tag);
        step(b, 1'b0, 0, 0, 0, 0, 1'b1, kind, idx, data, tag);
    endtask

    task automatic acc(input bit b, input int mode, input int p, input int ms, input int imm,
                       input string tag);
        step(b, 1'b1, mode, p, ms, imm, 1'b0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++) begin
            m_page[b] = 0;
            for (int i = 0; i < 4; i++) begin
                m_ptr[b][i] = 0; m_mod[b][i] = 0; m_len[b][i] = 0; m_base[b][i] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(addr_valid == 1'b0, "R1 valid low in reset", int'(addr_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(addr_valid == 1'b0, "R12 idle after reset", int'(addr_valid), 0);

        // R1: zeroed registers in both sets
        acc(1'b0, 0, 1, 2, 0, "R1 primary zero");
        acc(1'b1, 1, 3, 3, 0, "R1 secondary zero");

        // window base 0x100 length 10 on pointer 2, page 0x7A
        wr(1'b0, 4, 0, 16'h007A, "setup");
        wr(1'b0, 3, 2, 16'h0100, "setup");
        wr(1'b0, 2, 2, 10, "setup");
        wr(1'b0, 0, 2, 16'h0105, "setup");
        wr(1'b0, 1, 1, 3, "setup");
        wr(1'b0, 1, 2, 16'hFFFC, "setup");
        acc(1'b0, 0, 2, 1, 0, "R2 post reg");          // out 0x105, ptr 0x108
        acc(1'b0, 0, 2, 1, 0, "R7 upper fold");        // out 0x108, ptr 0x101
        acc(1'b0, 0, 2, 2, 0, "R8 lower fold");        // out 0x101, ptr 0x107
        check(m_ptr[0][2] == 16'h0107, "R8 model", m_ptr[0][2], 16'h0107);
        acc(1'b0, 1, 2, 1, 0, "R3 pre keep");          // out 0x100, ptr stays 0x107
        acc(1'b0, 3, 2, 0, 0, "R3 pointer kept");      // out 0x107
        acc(1'b0, 2, 2, 0, 8'hFE, "R4 pre imm");       // out 0x105, stored
        acc(1'b0, 3, 2, 0, 1, "R5 post imm");          // out 0x105, ptr 0x106
        acc(1'b0, 3, 2, 0, 0, "R5 after post imm");    // out 0x106

        // R6 and R9: zero length rolls over, page untouched
        wr(1'b0, 0, 0, 16'hFFFE, "setup");
        wr(1'b0, 1, 0, 5, "setup");
        acc(1'b0, 0, 0, 0, 0, "R6 rollover post");
        acc(1'b0, 3, 0, 0, 0, "R9 page after carry");  // out {7A,0003}
        check(m_ptr[0][0] == 3, "R6 model", m_ptr[0][0], 3);
        acc(1'b0, 2, 0, 0, 8'h80, "R9 borrow keeps page");

        // R10: set switching
        acc(1'b1, 3, 0, 0, 0, "R10 secondary untouched");
        wr(1'b1, 4, 0, 16'h0033, "setup");
        wr(1'b1, 0, 0, 16'h1234, "setup");
        acc(1'b1, 0, 0, 0, 0, "R10 secondary access");
        acc(1'b0, 3, 0, 0, 0, "R10 primary retained");
        acc(1'b0, 3, 2, 0, 0, "R10 primary window kept");

        // R11: write wins over update on the same pointer
        step(1'b0, 1'b1, 0, 2, 1, 0, 1'b1, 0, 2, 16'h4444, "R11 collision");
        acc(1'b0, 3, 2, 0, 0, "R11 written value");
        step(1'b0, 1'b1, 3, 1, 0, 5, 1'b1, 0, 3, 16'h0777, "R11 other pointer");
        acc(1'b0, 3, 1, 0, 0, "R11 update kept");
        acc(1'b0, 3, 3, 0, 0, "R11 write kept");

        // idle cycle
        @(negedge clk);
        check(addr_valid == 1'b0, "R12 no access", int'(addr_valid), 0);

        // seeded random windows and accesses
        for (int it = 0; it < 300; it++) begin
            bit b;
            int p;
            int ms;
            int len;
            int base;
            int lim;
            b   = 1'($urandom);
            p   = int'($urandom_range(3, 0));
            ms  = int'($urandom_range(3, 0));
            len = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(200, 1));
            base = int'($urandom_range(65536 - len, 0));
            if (base + len > 65536) base = 65536 - len;
            wr(b, 4, 0, int'($urandom_range(255, 0)), "setup");
            wr(b, 3, p, base, "setup");
            wr(b, 2, p, len, "setup");
            if (len == 0) begin
                wr(b, 0, p, int'($urandom_range(65535, 0)), "setup");
                wr(b, 1, ms, int'($urandom_range(65535, 0)), "setup");
            end else begin
                int mag;
                wr(b, 0, p, base + int'($urandom_range(len - 1, 0)), "setup");
                mag = int'($urandom_range(len - 1, 0));
                wr(b, 1, ms, ($urandom_range(1, 0) != 0) ? mag : ((65536 - mag) & 16'hFFFF),
                   "setup");
            end
            lim = (len == 0 || len > 128) ? 128 : len;
            for (int k = 0; k < 8; k++) begin
                int md;
                int im;
                md = int'($urandom_range(3, 0));
                im = int'($urandom_range(lim - 1, 0));
                if ($urandom_range(1, 0) != 0) im = -im;
                if (len == 0) im = int'($urandom_range(255, 0));
                case (md)
                    0: acc(b, md, p, ms, im, "R2 random");
                    1: acc(b, md, p, ms, im, "R3 random");
                    2: acc(b, md, p, ms, im, "R4 random");
                    default: acc(b, md, p, ms, im, "R5 random");
                endcase
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule